// File: doc/BRIEF.md
# Power-Up Strap Capture and Clock-Mode Decoder

This block manages a package pin that does two jobs. While the chip's supplies come up, the pin serves as a configuration strap: its output driver stays off, and the board's resistor sets its level. Once a settling window has run out, the strap level is captured together with two dedicated select inputs. These three bits form a select word that is held in a register. From then on, the block turns the pin's output driver on and the pin carries the reference clock.

The held select word is decoded into the operating mode of the clock generator. There are three run modes, each with its own CPU clock rate. In these run modes the memory clock stays at 100 MHz and the bus clock stays at 33.3 MHz. There is also a mode that floats every output and a factory test mode. An undriven strap reads as 0, because the pad has a weak pull-down. The power-on reset input stands in for supply-ramp detection. The length of the settling window is set by a parameter, counted in reference-clock cycles. All three select bits pass through a two-flop synchroniser before they are captured.

Top module: `strap_latch`

## Requirements
- R1: While `rstN` is low: `padOe`=0, `padOut`=0, `selValid`=0, `tristateAll`=0, `testMode`=0 and `cpuFreq`=2'b11.
- R2: After `rstN` is released, `padOe` stays 0 for the first `SETTLE_CYCLES` rising edges. It first reads 1 after edge `SETTLE_CYCLES`+1, and `selValid` rises at the same edge.
- R3: `latchedSel` is the word {`strapIn`, `selMidIn`, `selLowIn`} as it stood at rising edge `SETTLE_CYCLES`-1 after reset release. A change applied after that edge is not captured.
- R4: Once `selValid` is 1, changes on the three select inputs leave `latchedSel`, `cpuFreq`, `tristateAll` and `testMode` unchanged until the next reset.
- R5: While `padOe` is 0, `padOut` is 0. From the edge where `padOe` rises, `padOut` starts at 0 and inverts on every following rising edge, so it carries the reference clock at half rate.
- R6: With `latchedSel[1]`=1, `cpuFreq` decodes as follows: 3'b010 gives 2'b00 (66.6 MHz), 3'b011 gives 2'b01 (100 MHz), and 3'b11x gives 2'b10 (133.3 MHz). In these cases both flags are 0.
- R7: With `latchedSel[1:0]`=2'b00, whatever `latchedSel[2]` is, `tristateAll`=1, `testMode`=0 and `cpuFreq`=2'b11.
- R8: With `latchedSel[1:0]`=2'b01, whatever `latchedSel[2]` is, `testMode`=1, `tristateAll`=0 and `cpuFreq`=2'b11.
- R9: Asserting `rstN` again restarts the settling window. The next capture takes the new input values, not the ones held before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Power-on reset, asynchronous, active low |
| strapIn | input | 1 | Level seen at the shared pad (select bit 2) |
| selMidIn | input | 1 | Dedicated select input (select bit 1) |
| selLowIn | input | 1 | Dedicated select input (select bit 0) |
| padOe | output | 1 | Output enable of the shared pad driver |
| padOut | output | 1 | Data driven onto the shared pad when enabled |
| selValid | output | 1 | Select word has been captured |
| latchedSel | output | 3 | Captured select word {bit2, bit1, bit0} |
| cpuFreq | output | 2 | CPU rate code: 00 66.6, 01 100, 10 133.3, 11 no run clock |
| tristateAll | output | 1 | All clock outputs float |
| testMode | output | 1 | Test mode selected |

## Verification
The hardest case to reach from the ports is the capture boundary. Because of the synchroniser, the captured word is the value present two edges before the strobe, not the value present at the strobe. The stimulus therefore switches the inputs on a chosen edge inside the window and covers both sides of the boundary: one trial switches after edge `SETTLE_CYCLES`-2 and must capture the new word, and another switches after edge `SETTLE_CYCLES`-1 and must keep the old one. Random trials then place the switch anywhere from early in the window to well after the pad has turned around.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [1:0] {
    CPU_F66  = 2'b00,
    CPU_F100 = 2'b01,
    CPU_F133 = 2'b10,
    CPU_OFF  = 2'b11
  } cpu_freq_e;

  typedef struct packed {
    logic latchEn;
    logic driveEn;
  } strobe_t;
endpackage

// File: rtl/strap_ctrl.sv
module strap_ctrl
  import strap_pkg::*;
#(
  parameter int SETTLE_CYCLES = 32
) (
  input  logic    clk,
  input  logic    rstN,
  output strobe_t strobes
);
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SETTLE_CYCLES - 1);

  typedef enum logic [1:0] {ST_SETTLE, ST_LATCH, ST_DRIVE} state_e;

  state_e            state;
  logic [CNT_W-1:0]  settleCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_SETTLE;
      settleCnt <= '0;
    end else begin
      unique case (state)
        ST_SETTLE: begin
          if (settleCnt == LAST_CNT) state <= ST_LATCH;
          else                       settleCnt <= settleCnt + 1'b1;
        end
        ST_LATCH: state <= ST_DRIVE;
        default:  state <= ST_DRIVE;
      endcase
    end
  end

  always_comb begin
    strobes.latchEn = (state == ST_LATCH);
    strobes.driveEn = (state == ST_DRIVE);
  end

  // R2: counter never runs past the window
  p_window_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SETTLE) |-> (settleCnt < CNT_W'(SETTLE_CYCLES)));

  // R4: the capture strobe fires once per reset
  p_single_strobe_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.latchEn |=> !strobes.latchEn);

  // R2: the driver is only enabled after the capture strobe
  p_drive_after_latch_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobes.driveEn) |-> $past(strobes.latchEn));
endmodule

// File: rtl/strap_dp.sv
module strap_dp
  import strap_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobes,
  input  logic             strapIn,
  input  logic             selMidIn,
  input  logic             selLowIn,
  output logic             padOe,
  output logic             padOut,
  output logic             selValid,
  output logic [SEL_W-1:0] latchedSel,
  output logic [1:0]       cpuFreq,
  output logic             tristateAll,
  output logic             testMode
);
  logic [SEL_W-1:0] syncA, syncB;
  logic             toggleQ;
  cpu_freq_e        freqDec;
  logic             floatDec, testDec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= {strapIn, selMidIn, selLowIn};
      syncB <= syncA;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchedSel <= '0;
      selValid   <= 1'b0;
    end else if (strobes.latchEn && !selValid) begin
      latchedSel <= syncB;
      selValid   <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                toggleQ <= 1'b0;
    else if (strobes.driveEn) toggleQ <= ~toggleQ;
    else                      toggleQ <= 1'b0;
  end

  always_comb begin
    freqDec  = CPU_OFF;
    floatDec = 1'b0;
    testDec  = 1'b0;
    if (!latchedSel[1]) begin
      if (latchedSel[0]) testDec  = 1'b1;
      else               floatDec = 1'b1;
    end else if (latchedSel[2]) begin
      freqDec = CPU_F133;
    end else begin
      freqDec = latchedSel[0] ? CPU_F100 : CPU_F66;
    end
  end

  assign padOe       = strobes.driveEn;
  assign padOut      = strobes.driveEn & toggleQ;
  assign cpuFreq     = selValid ? freqDec : CPU_OFF;
  assign tristateAll = selValid & floatDec;
  assign testMode    = selValid & testDec;

  // R4: the captured word never moves after capture
  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    selValid |=> (selValid && $stable(latchedSel)));

  // R5: pad quiet while the driver is off
  p_quiet_pad_r5: assert property (@(posedge clk) disable iff (!rstN)
    !padOe |-> !padOut);

  // R5: pad toggles every cycle while driven
  p_toggle_r5: assert property (@(posedge clk) disable iff (!rstN)
    (padOe && $past(padOe)) |-> (padOut != $past(padOut)));

  // R7: tristate and test flags are exclusive
  p_mode_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({tristateAll, testMode}));

  // R8: no run clock code in non-run modes
  p_off_code_r8: assert property (@(posedge clk) disable iff (!rstN)
    (tristateAll || testMode) |-> (cpuFreq == 2'b11));
endmodule

// File: rtl/strap_latch.sv
module strap_latch
  import strap_pkg::*;
#(
  parameter int SETTLE_CYCLES = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       strapIn,
  input  logic       selMidIn,
  input  logic       selLowIn,
  output logic       padOe,
  output logic       padOut,
  output logic       selValid,
  output logic [2:0] latchedSel,
  output logic [1:0] cpuFreq,
  output logic       tristateAll,
  output logic       testMode
);
  strobe_t strobes;

  strap_ctrl #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes)
  );

  strap_dp u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .strapIn     (strapIn),
    .selMidIn    (selMidIn),
    .selLowIn    (selLowIn),
    .padOe       (padOe),
    .padOut      (padOut),
    .selValid    (selValid),
    .latchedSel  (latchedSel),
    .cpuFreq     (cpuFreq),
    .tristateAll (tristateAll),
    .testMode    (testMode)
  );
endmodule

// File: tb/strap_latch_tb.sv
`timescale 1ns/1ps
module strap_latch_tb;
  localparam int SETTLE = 32;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       strapIn = 1'b0, selMidIn = 1'b0, selLowIn = 1'b0;
  logic       padOe, padOut, selValid, tristateAll, testMode;
  logic [2:0] latchedSel;
  logic [1:0] cpuFreq;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  strap_latch #(.SETTLE_CYCLES(SETTLE)) u_dut (
    .clk(clk), .rstN(rstN), .strapIn(strapIn), .selMidIn(selMidIn),
    .selLowIn(selLowIn), .padOe(padOe), .padOut(padOut), .selValid(selValid),
    .latchedSel(latchedSel), .cpuFreq(cpuFreq), .tristateAll(tristateAll),
    .testMode(testMode)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] expFreq(input logic [2:0] s);
    if (!s[1])    return 2'b11;
    else if (s[2]) return 2'b10;
    else          return s[0] ? 2'b01 : 2'b00;
  endfunction

  task automatic setSel(input logic [2:0] s);
    {strapIn, selMidIn, selLowIn} = s;
  endtask

  // changeAt: input switches to 'second' right after that edge (0 = never)
  task automatic runTrial(input logic [2:0] first, input logic [2:0] second,
                          input int changeAt, output logic [2:0] captured);
    int firstOe = 0;
    bit toggleOk = 1'b1;
    bit quietOk = 1'b1;
    logic [2:0] expSel;
    rstN = 1'b0;
    setSel(first);
    repeat (2) @(negedge clk);
    check(padOe == 0 && padOut == 0 && selValid == 0, "R1", "pad/valid in reset",
          {padOe, padOut, selValid}, 0);
    check(cpuFreq == 2'b11 && !tristateAll && !testMode, "R1", "mode outputs in reset",
          {cpuFreq, tristateAll, testMode}, 12);
    rstN = 1'b1;
    for (int k = 1; k <= SETTLE + 5; k++) begin
      @(negedge clk);
      if (padOe && firstOe == 0) firstOe = k;
      if (!padOe && padOut) quietOk = 1'b0;
      if (k >= SETTLE + 1 && padOut != logic'((k - SETTLE - 1) % 2)) toggleOk = 1'b0;
      if (k == changeAt) setSel(second);
    end
    expSel = (changeAt != 0 && changeAt <= SETTLE - 2) ? second : first;
    check(firstOe == SETTLE + 1, "R2", "first edge with padOe", firstOe, SETTLE + 1);
    check(selValid == 1'b1, "R2", "selValid after window", selValid, 1);
    check(quietOk, "R5", "padOut low while disabled", 0, 1);
    check(toggleOk, "R5", "padOut half-rate toggle", 0, 1);
    check(latchedSel == expSel, "R3", "captured word", latchedSel, expSel);
    check(cpuFreq == expFreq(expSel), expSel[1] ? "R6" : (expSel[0] ? "R8" : "R7"),
          "cpuFreq", cpuFreq, expFreq(expSel));
    check(tristateAll == (expSel[1:0] == 2'b00), "R7", "tristateAll",
          tristateAll, expSel[1:0] == 2'b00);
    check(testMode == (expSel[1:0] == 2'b01), "R8", "testMode",
          testMode, expSel[1:0] == 2'b01);
    setSel(~expSel);
    repeat (4) @(negedge clk);
    check(latchedSel == expSel && cpuFreq == expFreq(expSel), "R4",
          "word held after input change", latchedSel, expSel);
    captured = latchedSel;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [2:0] got;
    void'($urandom(32'd4711));
    // directed: every code, no change in window (R6 R7 R8)
    for (int s = 0; s < 8; s++) runTrial(3'(s), 3'(s), 0, got);
    // capture boundary (R3)
    runTrial(3'b010, 3'b111, SETTLE - 2, got);
    check(got == 3'b111, "R3", "switch before boundary captured", got, 3'b111);
    runTrial(3'b010, 3'b111, SETTLE - 1, got);
    check(got == 3'b010, "R3", "switch at boundary not captured", got, 3'b010);
    // change after turnaround ignored (R4)
    runTrial(3'b011, 3'b100, SETTLE + 3, got);
    // reset mid-window then a fresh capture (R9)
    rstN = 1'b0; setSel(3'b110);
    @(negedge clk); rstN = 1'b1;
    repeat (SETTLE / 2) @(negedge clk);
    runTrial(3'b001, 3'b001, 0, got);
    check(got == 3'b001, "R9", "recapture after reset", got, 3'b001);
    runTrial(3'b110, 3'b110, 0, got);
    check(got == 3'b110, "R9", "recapture after driven phase", got, 3'b110);
    // random trials
    for (int t = 0; t < 20; t++) begin
      logic [2:0] a, b;
      int at;
      a  = 3'($urandom_range(0, 7));
      b  = 3'($urandom_range(0, 7));
      at = $urandom_range(1, SETTLE + 5);
      runTrial(a, b, at, got);
    end
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule